// File: doc/BRIEF.md
# Floating-Point Exception Condition Classifier

This block sits beside a single-precision arithmetic unit and looks at each completed add, subtract, multiply or divide. It takes the operation code, both source operands and the result the unit produced, and decides which of five exception conditions apply. It never computes an arithmetic result of its own.

The trigger rules are deliberately not those of the IEEE-754 standard. A NaN result is reported as overflow, a denormal result as underflow, and any denormal source operand raises its own condition. Each classified operation with at least one condition yields a one-cycle exception request, a per-operation cause vector and sticky bits in a five-bit status register. Software clears or presets that register only through an explicit write.

Operands follow the IEEE-754 layout of sign, biased exponent and fraction. The widths of the exponent and fraction fields are parameters, and they default to single precision.

Top module: `fpx_classifier`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `exc_req`, `exc_cause` and `status` are all zero.
- R2: Cause bit 1 (underflow) is set for a classified operation whose result has a zero exponent and a nonzero fraction.
- R3: Cause bit 2 (overflow) is set for a classified operation whose result has an all-ones exponent and a nonzero fraction. A result that is infinite does not set it.
- R4: Cause bit 3 (divide-by-zero) is set only when `in_op` is 3 (divide), `op_b` (the divisor) is +0 or -0, and `op_a` is not infinite. Add (0), subtract (1) and multiply (2) never set it.
- R5: Cause bit 4 (invalid) is set when either operand is a signaling NaN: an all-ones exponent, a nonzero fraction and a fraction MSB of 0. A quiet NaN operand, whose fraction MSB is 1, does not set it.
- R6: Cause bit 4 is also set for these operand pairs: an add of two infinities of unlike sign; a subtract of two infinities of like sign; a multiply of zero by infinity in either order; a divide of zero by zero; a divide of infinity by infinity.
- R7: Cause bit 0 (denormal operand) is set when `op_a` or `op_b` has a zero exponent and a nonzero fraction.
- R8: `exc_req` is high in the cycle after a classified operation that has at least one cause bit set, and low in every other cycle.
- R9: `exc_cause` takes the cause vector of each classified operation one cycle later, and it holds its value while `in_valid` is low.
- R10: A status bit, once set, stays set until a status write is made.
- R11: A write (`st_wr` high) loads `st_wdata` into `status`. Causes detected in the same cycle are ORed on top of the written value.
- R12: With `in_valid` low, the operand, result and op inputs affect neither `exc_req` nor `status`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A completed operation is presented for classification |
| in_op | input | 2 | Operation: 0 add, 1 subtract, 2 multiply, 3 divide |
| op_a | input | 1+EXP_W+FRAC_W | First operand (dividend for a divide) |
| op_b | input | 1+EXP_W+FRAC_W | Second operand (divisor for a divide) |
| op_res | input | 1+EXP_W+FRAC_W | Result produced by the arithmetic unit |
| st_wr | input | 1 | Status register write strobe |
| st_wdata | input | 5 | Value loaded into the status register on a write |
| exc_req | output | 1 | Single-cycle exception request |
| exc_cause | output | 5 | Causes of the last classified operation: bit0 denormal operand, bit1 underflow, bit2 overflow, bit3 divide-by-zero, bit4 invalid |
| status | output | 5 | Sticky status bits, same bit layout as `exc_cause` |

## Verification
The bench builds the block with its default widths, an 8-bit exponent and a 23-bit fraction. Its hand-picked encodings for zeros, infinities, quiet and signaling NaNs and denormals therefore sit exactly on the field boundaries that the classifier decodes. At these widths it can set the single fraction MSB that separates a quiet NaN from a signaling one, and it can reach the smallest denormal and the largest finite exponent as neighbours of the special classes. A random phase draws operands and results from a pool of special values mixed with free bit patterns, and it interleaves status writes, so that write-versus-detect collisions happen many times.

// File: rtl/fpx_pkg.sv
package fpx_pkg;

  localparam int CAUSE_W = 5;

  // Cause and status bit positions (visible to software, so fixed)
  localparam int IDX_DNM = 0;  // denormal source operand
  localparam int IDX_UNF = 1;  // denormal result
  localparam int IDX_OVF = 2;  // NaN result
  localparam int IDX_DVZ = 3;  // divide by zero
  localparam int IDX_INV = 4;  // invalid operation

  typedef enum logic [1:0] {
    OP_ADD = 2'd0,
    OP_SUB = 2'd1,
    OP_MUL = 2'd2,
    OP_DIV = 2'd3
  } fpx_op_e;

  // Per-operand classification used by the rule logic
  typedef struct packed {
    logic sign;
    logic zero;
    logic inf;
    logic snan;
    logic denorm;
  } fpx_class_t;

endpackage

// File: rtl/fpx_operand_class.sv
module fpx_operand_class
  import fpx_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic [EXP_W+FRAC_W:0] value,
  output fpx_class_t            cls
);

  localparam int W = 1 + EXP_W + FRAC_W;

  logic [EXP_W-1:0]  exp_f;
  logic [FRAC_W-1:0] frac_f;
  logic              exp_all_ones;
  logic              exp_all_zero;
  logic              frac_nonzero;

  assign exp_f  = value[W-2:FRAC_W];
  assign frac_f = value[FRAC_W-1:0];

  assign exp_all_ones = &exp_f;
  assign exp_all_zero = ~|exp_f;
  assign frac_nonzero = |frac_f;

  always_comb begin
    cls.sign   = value[W-1];
    cls.zero   = exp_all_zero & ~frac_nonzero;
    cls.inf    = exp_all_ones & ~frac_nonzero;
    // Signaling NaN: quiet bit (fraction MSB) clear, some other fraction bit set
    cls.snan   = exp_all_ones & frac_nonzero & ~frac_f[FRAC_W-1];
    cls.denorm = exp_all_zero & frac_nonzero;
  end

endmodule

// File: rtl/fpx_rules.sv
module fpx_rules
  import fpx_pkg::*;
(
  input  fpx_op_e              op,
  input  fpx_class_t           a_cls,
  input  fpx_class_t           b_cls,
  input  logic                 res_nan,
  input  logic                 res_denorm,
  output logic [CAUSE_W-1:0]   cause
);

  logic both_inf;
  logic inf_clash;
  logic div_by_zero;

  assign both_inf = a_cls.inf & b_cls.inf;

  // Illegal infinite/zero operand pairings, selected by operation
  always_comb begin
    inf_clash = 1'b0;
    unique case (op)
      OP_ADD: inf_clash = both_inf & (a_cls.sign ^ b_cls.sign);
      OP_SUB: inf_clash = both_inf & ~(a_cls.sign ^ b_cls.sign);
      OP_MUL: inf_clash = (a_cls.zero & b_cls.inf) | (a_cls.inf & b_cls.zero);
      OP_DIV: inf_clash = (a_cls.zero & b_cls.zero) | both_inf;
      default: inf_clash = 1'b0;
    endcase
  end

  assign div_by_zero = (op == OP_DIV) & b_cls.zero & ~a_cls.inf;

  always_comb begin
    cause          = '0;
    cause[IDX_DNM] = a_cls.denorm | b_cls.denorm;
    cause[IDX_UNF] = res_denorm;
    cause[IDX_OVF] = res_nan;
    cause[IDX_DVZ] = div_by_zero;
    cause[IDX_INV] = a_cls.snan | b_cls.snan | inf_clash;
  end

endmodule

// File: rtl/fpx_status_reg.sv
module fpx_status_reg
  import fpx_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               det_valid,
  input  logic [CAUSE_W-1:0] det_cause,
  input  logic               wr_en,
  input  logic [CAUSE_W-1:0] wr_data,
  output logic               req_q,
  output logic [CAUSE_W-1:0] cause_q,
  output logic [CAUSE_W-1:0] status_q
);

  logic [CAUSE_W-1:0] live_cause;
  logic [CAUSE_W-1:0] status_base;

  assign live_cause  = det_valid ? det_cause : '0;
  assign status_base = wr_en ? wr_data : status_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q    <= 1'b0;
      cause_q  <= '0;
      status_q <= '0;
    end else begin
      req_q    <= |live_cause;
      if (det_valid) cause_q <= det_cause;
      status_q <= status_base | live_cause;
    end
  end

endmodule

// File: rtl/fpx_classifier.sv
module fpx_classifier
  import fpx_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic [1:0]               in_op,
  input  logic [EXP_W+FRAC_W:0]    op_a,
  input  logic [EXP_W+FRAC_W:0]    op_b,
  input  logic [EXP_W+FRAC_W:0]    op_res,
  input  logic                     st_wr,
  input  logic [4:0]               st_wdata,
  output logic                     exc_req,
  output logic [4:0]               exc_cause,
  output logic [4:0]               status
);

  localparam int W     = 1 + EXP_W + FRAC_W;
  localparam int N_SRC = 2;

  // Result checks kept as functions so the bench can restate them independently
  function automatic logic f_is_nan(input logic [W-1:0] v);
    return (&v[W-2:FRAC_W]) & (|v[FRAC_W-1:0]);
  endfunction

  function automatic logic f_is_denorm(input logic [W-1:0] v);
    return (~|v[W-2:FRAC_W]) & (|v[FRAC_W-1:0]);
  endfunction

  fpx_op_e            op_e;
  logic [W-1:0]       src [N_SRC];
  fpx_class_t         src_cls [N_SRC];
  logic               res_nan;
  logic               res_denorm;
  logic [CAUSE_W-1:0] det_cause;

  assign op_e   = fpx_op_e'(in_op);
  assign src[0] = op_a;
  assign src[1] = op_b;

  generate
    for (genvar gi = 0; gi < N_SRC; gi++) begin : g_src
      fpx_operand_class #(
        .EXP_W (EXP_W),
        .FRAC_W(FRAC_W)
      ) u_cls (
        .value(src[gi]),
        .cls  (src_cls[gi])
      );
    end
  endgenerate

  assign res_nan    = f_is_nan(op_res);
  assign res_denorm = f_is_denorm(op_res);

  fpx_rules u_rules (
    .op        (op_e),
    .a_cls     (src_cls[0]),
    .b_cls     (src_cls[1]),
    .res_nan   (res_nan),
    .res_denorm(res_denorm),
    .cause     (det_cause)
  );

  fpx_status_reg u_stat (
    .clk      (clk),
    .rst_n    (rst_n),
    .det_valid(in_valid),
    .det_cause(det_cause),
    .wr_en    (st_wr),
    .wr_data  (st_wdata),
    .req_q    (exc_req),
    .cause_q  (exc_cause),
    .status_q (status)
  );

endmodule

// File: rtl/fpx_checker.sv
module fpx_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic [1:0] in_op,
  input logic       res_nan,
  input logic       res_denorm,
  input logic [4:0] det_cause,
  input logic       st_wr,
  input logic       exc_req,
  input logic [4:0] exc_cause,
  input logic [4:0] status
);

  p_req_on_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (det_cause != 5'd0)) |=> exc_req);

  p_req_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && (det_cause != 5'd0)) |=> !exc_req);

  p_underflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && res_denorm) |=> exc_cause[1]);

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !res_nan) |=> !exc_cause[2]);

  p_no_divz_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (in_op != 2'd3)) |=> !exc_cause[3]);

  p_cause_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(exc_cause));

  p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !st_wr |=> ((status & $past(status)) == $past(status)));

  p_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && !st_wr) |=> ($stable(status) && !exc_req));

endmodule

bind fpx_classifier fpx_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_op     (in_op),
  .res_nan   (res_nan),
  .res_denorm(res_denorm),
  .det_cause (det_cause),
  .st_wr     (st_wr),
  .exc_req   (exc_req),
  .exc_cause (exc_cause),
  .status    (status)
);

// File: tb/fpx_classifier_tb.sv
`timescale 1ns/1ps
module fpx_classifier_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [1:0]  in_op = 2'd0;
  logic [31:0] op_a = '0, op_b = '0, op_res = '0;
  logic        st_wr = 1'b0;
  logic [4:0]  st_wdata = '0;
  logic        exc_req;
  logic [4:0]  exc_cause, status;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // Model state
  bit       m_req = 0;
  bit [4:0] m_cause = 0;
  bit [4:0] m_status = 0;
  bit [4:0] pend_q[$];

  always #2.5 clk = ~clk;

  fpx_classifier u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
    .op_a(op_a), .op_b(op_b), .op_res(op_res), .st_wr(st_wr),
    .st_wdata(st_wdata), .exc_req(exc_req), .exc_cause(exc_cause),
    .status(status)
  );

  // Behavioural restatement of the rules using integer field extraction
  function automatic bit [4:0] ref_cause(int op, int unsigned a, int unsigned b, int unsigned r);
    int unsigned ea = (a >> 23) & 255, fa = a & 32'h7FFFFF;
    int unsigned eb = (b >> 23) & 255, fb = b & 32'h7FFFFF;
    int unsigned er = (r >> 23) & 255, fr = r & 32'h7FFFFF;
    bit a_inf = (ea == 255) && (fa == 0), b_inf = (eb == 255) && (fb == 0);
    bit a_zero = (ea == 0) && (fa == 0), b_zero = (eb == 0) && (fb == 0);
    bit a_sn = (ea == 255) && (fa != 0) && (fa < 32'h400000);
    bit b_sn = (eb == 255) && (fb != 0) && (fb < 32'h400000);
    bit same_sign = ((a >> 31) == (b >> 31));
    bit inv;
    bit [4:0] c = 0;
    if (((ea == 0) && (fa != 0)) || ((eb == 0) && (fb != 0))) c[0] = 1;
    if ((er == 0) && (fr != 0)) c[1] = 1;
    if ((er == 255) && (fr != 0)) c[2] = 1;
    if ((op == 3) && b_zero && !a_inf) c[3] = 1;
    inv = a_sn || b_sn;
    if (op == 0 && a_inf && b_inf && !same_sign) inv = 1;
    if (op == 1 && a_inf && b_inf && same_sign) inv = 1;
    if (op == 2 && ((a_zero && b_inf) || (a_inf && b_zero))) inv = 1;
    if (op == 3 && ((a_zero && b_zero) || (a_inf && b_inf))) inv = 1;
    c[4] = inv;
    return c;
  endfunction

  task automatic check(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic compare_all(string tag);
    check(tag, "exc_req", exc_req, m_req);
    check(tag, "exc_cause", exc_cause, m_cause);
    check(tag, "status", status, m_status);
  endtask

  // One cycle: drive at negedge, model the edge, compare after posedge
  task automatic step(bit v, int op, int unsigned a, int unsigned b, int unsigned r,
                      bit wr, bit [4:0] wd, string tag);
    bit [4:0] c;
    @(negedge clk);
    in_valid = v; in_op = op[1:0]; op_a = a; op_b = b; op_res = r;
    st_wr = wr; st_wdata = wd;
    c = v ? ref_cause(op, a, b, r) : 5'd0;
    pend_q.push_back(c);
    @(posedge clk);
    c = pend_q.pop_front();
    m_req = (c != 0);
    if (v) m_cause = c;
    m_status = (wr ? wd : m_status) | c;
    #1;
    compare_all(tag);
  endtask

  task automatic op1(int op, int unsigned a, int unsigned b, int unsigned r, string tag);
    step(1, op, a, b, r, 0, 5'd0, tag);
  endtask

  localparam int unsigned ONE = 32'h3F800000, TWO = 32'h40000000, THREE = 32'h40400000;
  localparam int unsigned PINF = 32'h7F800000, NINF = 32'hFF800000;
  localparam int unsigned PZ = 32'h00000000, NZ = 32'h80000000;
  localparam int unsigned QNAN = 32'h7FC00000, SNAN = 32'h7F800001, SNAN2 = 32'hFFBFFFFF;
  localparam int unsigned DEN = 32'h00000010, DENMIN = 32'h00000001, MAXF = 32'h7F7FFFFF;

  function automatic int unsigned pick();
    int unsigned pool[12] = '{ONE, PINF, NINF, PZ, NZ, QNAN, SNAN, SNAN2, DEN, DENMIN, MAXF, TWO};
    if ($urandom_range(0, 2) == 0) return $urandom();
    return pool[$urandom_range(0, 11)];
  endfunction

  initial begin : watchdog
    #(200000 * 5);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    repeat (3) @(posedge clk);
    #1;
    compare_all("R1");            // during reset
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1;
    compare_all("R1");            // first cycle after release

    op1(0, ONE, TWO, THREE, "R8");          // clean add
    op1(0, ONE, TWO, DENMIN, "R2");         // denormal result
    op1(2, ONE, TWO, QNAN, "R3");           // NaN result -> overflow
    op1(2, MAXF, MAXF, PINF, "R3");         // infinite result, no overflow
    op1(3, ONE, PZ, PINF, "R4");
    op1(3, ONE, NZ, NINF, "R4");
    op1(3, PINF, PZ, PINF, "R4");           // infinite dividend: no div-by-zero
    op1(2, ONE, PZ, PZ, "R4");              // multiply by zero: no div-by-zero
    op1(0, SNAN, ONE, ONE, "R5");
    op1(1, ONE, SNAN2, ONE, "R5");
    op1(0, QNAN, ONE, ONE, "R5");           // quiet NaN ignored
    op1(0, PINF, NINF, ONE, "R6");
    op1(0, PINF, PINF, PINF, "R6");
    op1(1, NINF, NINF, ONE, "R6");
    op1(1, PINF, NINF, PINF, "R6");
    op1(2, PZ, NINF, ONE, "R6");
    op1(2, PINF, NZ, ONE, "R6");
    op1(3, PZ, NZ, ONE, "R6");
    op1(3, NINF, PINF, ONE, "R6");
    op1(1, DEN, ONE, ONE, "R7");
    op1(2, ONE, DENMIN, ONE, "R7");

    // Idle cycles with exception-looking inputs
    step(0, 3, SNAN, PZ, QNAN, 0, 5'd0, "R12");
    step(0, 0, DEN, NINF, DENMIN, 0, 5'd0, "R9");

    // Status writes
    step(0, 0, ONE, ONE, ONE, 1, 5'd0, "R11");
    op1(0, ONE, ONE, TWO, "R10");
    step(0, 0, ONE, ONE, ONE, 1, 5'b10101, "R11");
    step(1, 3, ONE, PZ, PINF, 1, 5'b00001, "R11");
    op1(3, PZ, PZ, QNAN, "R10");
    op1(3, PZ, PZ, QNAN, "R8");             // back-to-back requests

    for (int i = 0; i < 400; i++) begin
      bit wr = ($urandom_range(0, 9) == 0);
      step($urandom_range(0, 3) != 0, $urandom_range(0, 3), pick(), pick(), pick(),
           wr, 5'($urandom()), "R10");
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule